// File: doc/BRIEF.md
# Random-Jump Sequential Pattern Generator

This block produces a 32-bit test data stream for exercising logic that monitors a bus. Most of the time the word counts up by one on each active tick. At random moments the count is replaced by a pseudo-random value, and the plus-one run continues from there. The stream therefore consists of sequential runs broken by unpredictable discontinuities. Every discontinuity is flagged on a one-cycle reference strobe. An independent counter can tally this strobe to learn the true number of jumps, and an analyser watching only the data word can be judged against that tally.

The generator runs on an internal tick. With the divide enable high, the tick fires once every `DIV` system clocks (12 by default, for example 100 MHz down to about 8.33 MHz). With the divide enable low, it fires on every clock. A run enable freezes the whole generator when low.

Three pieces of state advance on each active tick:
- a 32-bit shift-register pseudo-random source;
- a 5-bit jump-delay timer;
- the loadable data counter.

When the timer has reached zero, the next active tick loads the counter from the random source and reloads the timer with a fresh delay taken from that source.

Top module: `seqjump_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `data_o` is 0 and `jump_o` is 0.
- R2: On an active tick whose timer value is non-zero, `data_o` becomes its previous value plus one (mod 2^32), and the timer decreases by one.
- R3: On an active tick whose timer value is zero, `data_o` is loaded with the current random-source state (before that tick's shift).
- R4: On that load the timer is reloaded with random-source bits [9:5]. A reloaded value d means d plus-one ticks follow before the next load, so d = 0 gives a load on the very next active tick.
- R5: The random source shifts right by one on every active tick. The new bit 31 is the XOR of bits 31, 30, 10 and 0, which gives a period of 2^32 - 1.
- R6: After every reset the random source restarts from the `SEED` parameter, and the timer starts from `SEED[9:5]`. A zero `SEED` is replaced by 1.
- R7: `jump_o` is high in the cycle after an active tick that loaded the counter, and low otherwise. It is high for exactly one cycle per load.
- R8: With `div_en` high, active ticks occur only on clocks where the internal divider has reached `DIV`-1, which is once every `DIV` clocks counted from reset. With `div_en` low, every clock is a tick and the divider restarts from 0.
- R9: With `run_en` low, `data_o`, the random source and the timer hold their values, and `jump_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_en | input | 1 | 1: tick every `DIV` clocks; 0: tick every clock |
| run_en | input | 1 | 1: generator advances on ticks; 0: freeze |
| data_o | output | 32 | Generated data word |
| jump_o | output | 1 | One-cycle reference strobe per random jump |

## Verification
The load and the plus-one step compete for the same counter update on the tick where the timer sits at zero. When a reloaded delay is zero, loads also fall on consecutive ticks, and the strobe stays high across back-to-back cycles while each load still has to take the current shifted source value. These collisions are provoked by long free runs with `div_en` low, by random toggling of `run_en` and `div_en`, and by an instance with a zero seed whose first two ticks are both loads. A behavioural model in the bench predicts `data_o` and `jump_o` for every clock and is compared on each one.

// File: rtl/sjg_pkg.sv
package sjg_pkg;
    localparam int unsigned DATA_W_DEF  = 32;
    localparam int unsigned DLY_W_DEF   = 5;
    localparam int unsigned DLY_LSB_DEF = 5;
    localparam int unsigned DIV_DEF     = 12;
    localparam logic [31:0] TAPS_DEF    = 32'hC000_0401; // bits 31,30,10,0
    localparam logic [31:0] SEED_DEF    = 32'hACE1_2B57;

    // A zero shift-register state would lock the source, so replace it by 1.
    function automatic logic [31:0] nonzero_seed(input logic [31:0] s);
        return (s == '0) ? 32'd1 : s;
    endfunction
endpackage

// File: rtl/sjg_tick_div.sv
module sjg_tick_div #(
    parameter int unsigned DIV = sjg_pkg::DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_en,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (!div_en) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = div_en ? wrap : 1'b1;
endmodule

// File: rtl/sjg_lfsr.sv
module sjg_lfsr #(
    parameter int unsigned W    = sjg_pkg::DATA_W_DEF,
    parameter logic [W-1:0] TAPS = sjg_pkg::TAPS_DEF,
    parameter logic [W-1:0] SEED = sjg_pkg::SEED_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] SEED_NZ = (SEED == '0) ? W'(1) : SEED;

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_state_t;

    lfsr_state_t st_d, st_q;
    logic        fb;

    always_comb begin
        st_d = st_q;
        fb   = ^(st_q.sr & TAPS);
        if (adv) begin
            st_d.sr = {fb, st_q.sr[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr <= SEED_NZ;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.sr;
endmodule

// File: rtl/sjg_jump_timer.sv
module sjg_jump_timer #(
    parameter int unsigned DLY_W = sjg_pkg::DLY_W_DEF,
    parameter logic [DLY_W-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [DLY_W-1:0] reload_val,
    output logic             expired
);
    typedef struct packed {
        logic [DLY_W-1:0] remain;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        expired = (st_q.remain == '0);
        if (adv) begin
            if (expired) begin
                st_d.remain = reload_val;
            end else begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.remain <= INIT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/seqjump_gen.sv
module seqjump_gen #(
    parameter int unsigned DATA_W  = sjg_pkg::DATA_W_DEF,
    parameter int unsigned DLY_W   = sjg_pkg::DLY_W_DEF,
    parameter int unsigned DLY_LSB = sjg_pkg::DLY_LSB_DEF,
    parameter int unsigned DIV     = sjg_pkg::DIV_DEF,
    parameter logic [DATA_W-1:0] TAPS = sjg_pkg::TAPS_DEF,
    parameter logic [DATA_W-1:0] SEED = sjg_pkg::SEED_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_en,
    input  logic              run_en,
    output logic [DATA_W-1:0] data_o,
    output logic              jump_o
);
    localparam logic [DATA_W-1:0] SEED_NZ  = (SEED == '0) ? DATA_W'(1) : SEED;
    localparam logic [DLY_W-1:0]  DLY_INIT = SEED_NZ[DLY_LSB +: DLY_W];

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              jump;
    } gen_state_t;

    gen_state_t        st_d, st_q;
    logic              tick;
    logic              active;
    logic              expired;
    logic              load;
    logic [DATA_W-1:0] rnd;

    sjg_tick_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_en (div_en),
        .tick   (tick)
    );

    assign active = tick & run_en;

    sjg_lfsr #(.W(DATA_W), .TAPS(TAPS), .SEED(SEED_NZ)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (active),
        .state (rnd)
    );

    sjg_jump_timer #(.DLY_W(DLY_W), .INIT(DLY_INIT)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (active),
        .reload_val (rnd[DLY_LSB +: DLY_W]),
        .expired    (expired)
    );

    assign load = active & expired;

    always_comb begin
        st_d      = st_q;
        st_d.jump = load;
        if (load) begin
            st_d.word = rnd;
        end else if (active) begin
            st_d.word = st_q.word + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.word;
    assign jump_o = st_q.jump;
endmodule

// File: rtl/sjg_checker.sv
module sjg_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_en,
    input logic              run_en,
    input logic [DATA_W-1:0] data_o,
    input logic              jump_o
);
    AST_STEP_OR_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> (jump_o || data_o == $past(data_o) + 1'b1)); // R2

    AST_FROZEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(data_o)); // R9

    AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> $past(run_en)); // R7

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && jump_o && div_en) |=> !jump_o); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> (data_o == '0 && !jump_o)); // R1
endmodule

bind seqjump_gen sjg_checker #(.DATA_W(DATA_W), .DIV(DIV)) u_sjg_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_en (div_en),
    .run_en (run_en),
    .data_o (data_o),
    .jump_o (jump_o)
);

// File: tb/test_seqjump_gen.sv
`timescale 1ns/1ps
module test_seqjump_gen;
    localparam int          DIV  = 12;
    localparam logic [31:0] SEED = 32'hACE1_2B57;
    localparam logic [31:0] TAPS = 32'hC000_0401;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_en = 1'b0;
    logic        run_en = 1'b0;
    logic        z_run = 1'b0;
    logic [31:0] data_o, z_data;
    logic        jump_o, z_jump;

    always #2 clk = ~clk;

    seqjump_gen i_seqjump_gen (
        .clk(clk), .rst_n(rst_n), .div_en(div_en), .run_en(run_en),
        .data_o(data_o), .jump_o(jump_o)
    );

    seqjump_gen #(.SEED(32'h0)) i_seqjump_gen_zs (
        .clk(clk), .rst_n(rst_n), .div_en(1'b0), .run_en(z_run),
        .data_o(z_data), .jump_o(z_jump)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    m_jumps = 0;
    int    d_jumps = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    int          m_div = 0;
    logic [31:0] m_lfsr = SEED;
    logic [31:0] m_cnt = 0;
    int          m_tmr = 0;
    logic        m_jump = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_lfsr = SEED; m_cnt = 0;
            m_tmr = int'((SEED >> 5) & 32'd31); m_jump = 0;
        end else begin
            bit tick;
            bit act;
            tick = div_en ? (m_div == DIV - 1) : 1'b1;
            act  = tick && run_en;
            m_jump = 0;
            if (act) begin
                if (m_tmr == 0) begin
                    m_jump = 1;
                    m_cnt  = m_lfsr;
                    m_tmr  = int'((m_lfsr >> 5) & 32'd31);
                end else begin
                    m_cnt = m_cnt + 1;
                    m_tmr = m_tmr - 1;
                end
                m_lfsr = {^(m_lfsr & TAPS), m_lfsr[31:1]};
            end
            if (!div_en) m_div = 0;
            else m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            n_cmp++;
            if (m_jump) m_jumps++;
            if (jump_o) d_jumps++;
            if (data_o !== m_cnt || jump_o !== m_jump) begin
                n_bad++;
                $display("FAIL %s cyc %0d: data=%h jump=%b expected data=%h jump=%b",
                         cur_req, cyc, data_o, jump_o, m_cnt, m_jump);
            end
        end
    end

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_phase(input string req, input int n, input int mode);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (mode)
                1: begin run_en = ($urandom % 3) != 0; end
                2: begin div_en = ($urandom % 4) != 0; run_en = ($urandom % 8) != 0; end
                default: ;
            endcase
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        chk_on = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset data", data_o == 0, data_o, 0);
        check("R1 reset strobe", jump_o == 0, {31'd0, jump_o}, 0);
        rst_n = 1'b1;
        // R2 R3 R4 R5: free run, tick every clock
        div_en = 1'b0; run_en = 1'b1;
        run_phase("R2/R3/R4/R5 free run", 400, 0);
        check("R3 loads seen", m_jumps > 5, m_jumps, 5);
        // R9: random freezing
        run_phase("R9 run gating", 300, 1);
        run_en = 1'b1;
        // R8: divided tick
        div_en = 1'b1;
        run_phase("R8/R7 divided", 2400, 0);
        run_phase("R8/R9 mixed enables", 1500, 2);
        // R6: restart from seed mid-run
        div_en = 1'b0; run_en = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset again", data_o == 0, data_o, 0);
        rst_n = 1'b1;
        run_phase("R6 seed restart", 300, 0);
        // R6: zero seed becomes 1; SEED[9:5]=0 so two loads in a row
        @(negedge clk); z_run = 1'b1;
        @(negedge clk);
        check("R6 zero seed first load", z_data == 32'h1 && z_jump, z_data, 32'h1);
        @(negedge clk);
        check("R6 zero seed second load", z_data == 32'h8000_0000 && z_jump, z_data, 32'h8000_0000);
        z_run = 1'b0;
        @(negedge clk);
        check("R9 zero seed frozen", z_data == 32'h8000_0000 && !z_jump, z_data, 32'h8000_0000);
        check("R7 strobe tally", d_jumps == m_jumps, d_jumps, m_jumps);
        chk_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule